// File: doc/BRIEF.md
# Sequential FIR Filter Coprocessor

This block is a real-valued FIR filter engine that runs next to a processor. Software loads coefficients into a coefficient memory. It also writes a tap-count register with the filter length minus one, sets two base pointers (one for the coefficient region, one for the sample-history region) and programs a control register. A streaming writer, typically a DMA channel, pushes 24-bit samples into a small input FIFO. Whenever the filter state machine is idle and has room to deliver a result, it takes one sample from the FIFO and writes it into a circular history buffer. It then runs one multiply-accumulate per cycle over all taps, and rounds and saturates the sum back to 24 bits.

Each result lands in an output register with an availability flag. Software can poll this flag, or the block can raise an interrupt request from it. Reading the result clears the flag. In priming mode, the samples taken right after a control write only fill the history. Once the history holds a full window, every further sample yields exactly one result. In streaming mode, results start at the first sample and the missing history counts as zero.

Top module: `fir_cop`

## Requirements
- R1: Each result equals sat24((Σ_{i=0}^{N-1} H(i)·D(n−i) + 2^22) >>> 23). Coefficients H and samples D are 24-bit two's complement, so coefficients are Q1.23 fractions.
- R2: The tap register (address 1, bits [4:0]) holds N−1. A value of T makes the filter use exactly T+1 taps.
- R3: Tap i reads the coefficient memory at (cbase+i) mod 64, with the coefficient base at address 3. Samples are written at (dbase+wp) mod 64, with the data base at address 2. The write index wp steps modulo N.
- R4: The control register is at address 0, and its mode field is bits [5:4]. Only mode 00 (real FIR) consumes samples. With any other mode value, the FIFO is left untouched and no result is produced.
- R5: Control bit 7 selects the style. With bit 7 = 0 (priming), the first N−1 samples after a control write produce no result, and each later sample produces exactly one. With bit 7 = 1, every sample produces one result.
- R6: A write to the control register clears the whole sample history to zero and restarts the write index and the priming count.
- R7: out_valid rises when a result is written and falls in the cycle after out_rd. irq equals out_valid AND control bit 0.
- R8: in_full is high while the FIFO holds FIFO_DEPTH words (4 by default). A push while in_full is high is dropped.
- R9: A sum above the 24-bit range gives 0x7FFFFF, and a sum below it gives 0x800000.
- R10: While out_valid is high, no sample is taken from the FIFO, and out_data keeps its value until it is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 control, 1 taps, 2 data base, 3 coefficient base) |
| reg_wdata | input | 8 | Register write data |
| coef_we | input | 1 | Coefficient memory write strobe |
| coef_addr | input | 6 | Coefficient memory address |
| coef_wdata | input | 24 | Coefficient value |
| in_we | input | 1 | Sample push strobe |
| in_data | input | 24 | Sample value |
| in_full | output | 1 | Input FIFO full |
| out_rd | input | 1 | Result read strobe, clears out_valid |
| out_data | output | 24 | Latest result |
| out_valid | output | 1 | Result available |
| irq | output | 1 | Interrupt request |

## Verification
A fault in the circular write index or in the history base shows up at the ports as a wrong result. The first such result appears once N samples have wrapped the buffer, within N+2 cycles after the offending sample is taken. A priming counter that is off by one turns into a missing or extra result at exactly the N-th sample after a control write. A hold fault turns into a changed out_data while out_valid is still set. Every result is compared against a convolution model with the same rounding and clipping, and the checks include base pointers that wrap past the end of memory.

// File: rtl/fir_cop_pkg.sv
package fir_cop_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MAC  = 2'd1,
    ST_DONE = 2'd2
  } eng_st_t;

  localparam logic [1:0] RA_CTRL  = 2'd0;
  localparam logic [1:0] RA_TAPS  = 2'd1;
  localparam logic [1:0] RA_DBASE = 2'd2;
  localparam logic [1:0] RA_CBASE = 2'd3;

  localparam int CB_IRQEN = 0;
  localparam int CB_STYLE = 7;
  localparam int CB_MODE_LO = 4;
  localparam logic [1:0] MODE_REAL = 2'b00;
endpackage

// File: rtl/fir_cop_fifo.sv
module fir_cop_fifo #(
  parameter int W     = 24,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop,
  output logic [W-1:0]                 rdata,
  output logic                         full,
  output logic                         empty,
  output logic [$clog2(DEPTH+1)-1:0]   cnt
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp_q];
  assign cnt     = cnt_q;

  always_comb begin
    wp_n  = wp_q;
    rp_n  = rp_q;
    if (do_push) wp_n = (wp_q == PW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
    if (do_pop)  rp_n = (rp_q == PW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
    cnt_n = cnt_q + CW'(do_push) - CW'(do_pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata;
  end
endmodule

// File: rtl/fir_cop_mac.sv
module fir_cop_mac #(
  parameter int DW    = 24,
  parameter int GUARD = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 en,
  input  logic signed [DW-1:0] a,
  input  logic signed [DW-1:0] b,
  output logic        [DW-1:0] res
);
  localparam int PW = 2*DW;
  localparam int AW = PW + GUARD;
  localparam logic signed [AW-1:0] HALF = {{(AW-DW+1){1'b0}}, 1'b1, {(DW-2){1'b0}}};
  localparam logic signed [AW-1:0] SMAX = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [AW-1:0] SMIN = {{(AW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] acc_q, acc_n, rnd, shf;

  assign prod = a * b;

  always_comb begin
    acc_n = acc_q;
    if (clr)     acc_n = '0;
    else if (en) acc_n = acc_q + AW'(prod);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_n;
  end

  always_comb begin
    rnd = acc_q + HALF;
    shf = rnd >>> (DW-1);
    if (shf > SMAX)      res = SMAX[DW-1:0];
    else if (shf < SMIN) res = SMIN[DW-1:0];
    else                 res = shf[DW-1:0];
  end
endmodule

// File: rtl/fir_cop.sv
module fir_cop
  import fir_cop_pkg::*;
#(
  parameter int DW         = 24,
  parameter int MEM_DEPTH  = 64,
  parameter int MAX_TAPS   = 32,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_we,
  input  logic [1:0]                    reg_addr,
  input  logic [7:0]                    reg_wdata,
  input  logic                          coef_we,
  input  logic [$clog2(MEM_DEPTH)-1:0]  coef_addr,
  input  logic [DW-1:0]                 coef_wdata,
  input  logic                          in_we,
  input  logic [DW-1:0]                 in_data,
  output logic                          in_full,
  input  logic                          out_rd,
  output logic [DW-1:0]                 out_data,
  output logic                          out_valid,
  output logic                          irq
);
  localparam int MAW = $clog2(MEM_DEPTH);
  localparam int TW  = $clog2(MAX_TAPS);
  localparam int FCW = $clog2(FIFO_DEPTH+1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_in;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_in = rs_q[1];

  // programmable registers
  logic [1:0]     mode_q;
  logic           style_q, irqen_q;
  logic [TW-1:0]  taps_q;
  logic [MAW-1:0] dbase_q, cbase_q;
  logic           restart;
  logic           unused_wbits;

  assign restart      = reg_we && (reg_addr == RA_CTRL);
  assign unused_wbits = ^{reg_wdata[6], reg_wdata[3:1]};

  always_ff @(posedge clk or negedge rst_in) begin
    if (!rst_in) begin
      mode_q <= MODE_REAL; style_q <= 1'b0; irqen_q <= 1'b0;
      taps_q <= '0; dbase_q <= '0; cbase_q <= '0;
    end else begin
      if (restart) begin
        mode_q  <= reg_wdata[CB_MODE_LO+1:CB_MODE_LO];
        style_q <= reg_wdata[CB_STYLE];
        irqen_q <= reg_wdata[CB_IRQEN];
      end
      if (reg_we && reg_addr == RA_TAPS)  taps_q  <= reg_wdata[TW-1:0];
      if (reg_we && reg_addr == RA_DBASE) dbase_q <= reg_wdata[MAW-1:0];
      if (reg_we && reg_addr == RA_CBASE) cbase_q <= reg_wdata[MAW-1:0];
    end
  end

  // memories
  logic [DW-1:0]  cmem [MEM_DEPTH];
  logic [DW-1:0]  dmem [MEM_DEPTH];
  logic [MAW-1:0] dm_waddr, dm_raddr, cm_raddr;
  logic           dm_we;

  always_ff @(posedge clk) begin
    if (coef_we) cmem[coef_addr] <= coef_wdata;
  end

  // FIFO and engine state
  logic [DW-1:0]  fifo_rdata;
  logic           fifo_empty, eng_pop;
  logic [FCW-1:0] fifo_cnt;

  fir_cop_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_in), .push(in_we), .wdata(in_data), .pop(eng_pop),
    .rdata(fifo_rdata), .full(in_full), .empty(fifo_empty), .cnt(fifo_cnt)
  );

  eng_st_t        st_q, st_n;
  logic [TW-1:0]  k_q, k_n, rp_q, rp_n, wp_q, wp_n, fill_q, fill_n;
  logic           ov_q, ov_n, mac_clr, mac_en;
  logic [DW-1:0]  od_q, od_n, mac_res;

  assign dm_waddr = dbase_q + MAW'(wp_q);
  assign dm_raddr = dbase_q + MAW'(rp_q);
  assign cm_raddr = cbase_q + MAW'(k_q);

  always_ff @(posedge clk or negedge rst_in) begin
    if (!rst_in) begin
      for (int i = 0; i < MEM_DEPTH; i++) dmem[i] <= '0;
    end else if (restart) begin
      for (int i = 0; i < MEM_DEPTH; i++) dmem[i] <= '0;
    end else if (dm_we) begin
      dmem[dm_waddr] <= fifo_rdata;
    end
  end

  fir_cop_mac #(.DW(DW), .GUARD(TW)) u_mac (
    .clk(clk), .rst_n(rst_in), .clr(mac_clr), .en(mac_en),
    .a(cmem[cm_raddr]), .b(dmem[dm_raddr]), .res(mac_res)
  );

  always_comb begin
    st_n = st_q; k_n = k_q; rp_n = rp_q; wp_n = wp_q; fill_n = fill_q;
    ov_n = ov_q; od_n = od_q;
    eng_pop = 1'b0; mac_clr = 1'b0; mac_en = 1'b0; dm_we = 1'b0;
    if (out_rd) ov_n = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (mode_q == MODE_REAL && !fifo_empty && !ov_q) begin
          eng_pop = 1'b1; dm_we = 1'b1; mac_clr = 1'b1;
          k_n = '0; rp_n = wp_q; st_n = ST_MAC;
        end
      end
      ST_MAC: begin
        mac_en = 1'b1;
        k_n    = k_q + 1'b1;
        rp_n   = (rp_q == '0) ? taps_q : rp_q - 1'b1;
        if (k_q == taps_q) st_n = ST_DONE;
      end
      ST_DONE: begin
        wp_n = (wp_q == taps_q) ? '0 : wp_q + 1'b1;
        if (style_q || fill_q == taps_q) begin
          ov_n = 1'b1;
          od_n = mac_res;
        end else begin
          fill_n = fill_q + 1'b1;
        end
        st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
    if (restart) begin
      wp_n = '0; fill_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_in) begin
    if (!rst_in) begin
      st_q <= ST_IDLE; k_q <= '0; rp_q <= '0; wp_q <= '0; fill_q <= '0;
      ov_q <= 1'b0; od_q <= '0;
    end else begin
      st_q <= st_n; k_q <= k_n; rp_q <= rp_n; wp_q <= wp_n; fill_q <= fill_n;
      ov_q <= ov_n; od_q <= od_n;
    end
  end

  assign out_data  = od_q;
  assign out_valid = ov_q;
  assign irq       = ov_q && irqen_q;
endmodule

// File: rtl/fir_cop_chk.sv
module fir_cop_chk #(
  parameter int DW  = 24,
  parameter int TW  = 5,
  parameter int FCW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_we,
  input logic           in_full,
  input logic           out_rd,
  input logic           out_valid,
  input logic [DW-1:0]  out_data,
  input logic           irq,
  input logic           pop,
  input logic [FCW-1:0] fifo_cnt,
  input logic [1:0]     mode,
  input logic           in_mac,
  input logic [TW-1:0]  k,
  input logic [TW-1:0]  taps
);
  p_drop_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_full && in_we && !pop) |=> $stable(fifo_cnt));

  p_irq_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> out_valid);

  p_rd_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_rd) |=> !out_valid);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_rd) |=> (out_valid && $stable(out_data)));

  p_no_pop_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !pop);

  p_mode_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b00) |-> !pop);

  p_tap_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_mac |-> (k <= taps));
endmodule

bind fir_cop fir_cop_chk #(.DW(DW), .TW(TW), .FCW(FCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_we(in_we), .in_full(in_full), .out_rd(out_rd),
  .out_valid(out_valid), .out_data(out_data), .irq(irq), .pop(eng_pop),
  .fifo_cnt(fifo_cnt), .mode(mode_q), .in_mac(st_q == ST_MAC), .k(k_q), .taps(taps_q)
);

// File: tb/sim_fir_cop.sv
module sim_fir_cop;
  logic        clk, rst_n;
  logic        reg_we, coef_we, in_we, out_rd;
  logic [1:0]  reg_addr;
  logic [7:0]  reg_wdata;
  logic [5:0]  coef_addr;
  logic [23:0] coef_wdata, in_data, out_data;
  logic        in_full, out_valid, irq;

  int errors = 0;
  int checks = 0;

  localparam int NS = 28;
  localparam int SAMPLES [NS] = '{
    1200000, -3000000, 8388607, -8388608, 15, 500000, -777777, 2222222,
    0, -1, 4194304, -4194304, 123456, 6543210, -6000000, 99999,
    3141592, -2718281, 1000, -5000, 7000000, -7000000, 31415, 8000000,
    -250000, 1, 2, -3 };

  fir_cop u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .coef_we(coef_we), .coef_addr(coef_addr), .coef_wdata(coef_wdata),
    .in_we(in_we), .in_data(in_data), .in_full(in_full), .out_rd(out_rd),
    .out_data(out_data), .out_valid(out_valid), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // behavioural model
  longint mh [64];
  longint cf [64];
  int     ntap;

  task automatic model_reset();
    for (int i = 0; i < 64; i++) mh[i] = 0;
  endtask

  task automatic model_push(input longint x, output longint y);
    longint acc;
    for (int i = 63; i > 0; i--) mh[i] = mh[i-1];
    mh[0] = x;
    acc = 0;
    for (int i = 0; i < ntap; i++) acc += cf[i] * mh[i];
    y = (acc + (64'sd1 <<< 22)) >>> 23;
    if (y > 8388607) y = 8388607;
    if (y < -8388608) y = -8388608;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] a, input int d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = 8'(d);
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic load_coefs(input int base, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); coef_we = 1'b1; coef_addr = 6'((base + i) % 64); coef_wdata = 24'(cf[i]);
    end
    @(negedge clk); coef_we = 1'b0;
  endtask

  task automatic push(input longint x);
    @(negedge clk);
    while (in_full) @(negedge clk);
    in_we = 1'b1; in_data = 24'(x);
    @(negedge clk); in_we = 1'b0;
  endtask

  task automatic push_raw(input longint x);
    @(negedge clk); in_we = 1'b1; in_data = 24'(x);
    @(negedge clk); in_we = 1'b0;
  endtask

  task automatic wait_valid(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 300; i++) begin
      if (out_valid) begin ok = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic expect_out(input string tag, input longint exp);
    bit ok;
    wait_valid(ok);
    if (!ok) chk({tag, " no result"}, 0, 1);
    else     chk(tag, longint'($signed(out_data)), exp);
    out_rd = 1'b1;
    @(negedge clk); out_rd = 1'b0;
  endtask

  task automatic expect_none(input string tag);
    repeat (60) @(negedge clk);
    chk(tag, longint'(out_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired (all requirements)");
    summary();
    $finish;
  end

  initial begin
    longint y, ya, yb;
    bit ok;
    rst_n = 1'b0; reg_we = 0; coef_we = 0; in_we = 0; out_rd = 0;
    reg_addr = 0; reg_wdata = 0; coef_addr = 0; coef_wdata = 0; in_data = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // reset state (R7, R8)
    chk("R7 reset out_valid", longint'(out_valid), 0);
    chk("R7 reset irq", longint'(irq), 0);
    chk("R8 reset in_full", longint'(in_full), 0);

    // 20 taps, 28 samples, priming mode, data base wraps (R1 R2 R3 R5)
    ntap = 20;
    for (int i = 0; i < ntap; i++) cf[i] = longint'(((i*37 + 5) % 41) - 20) * 16411;
    load_coefs(7, ntap);
    wreg(2'd1, 19);
    wreg(2'd2, 50);
    wreg(2'd3, 7);
    wreg(2'd0, 8'h00);
    model_reset();
    for (int n = 0; n < NS; n++) begin
      push(SAMPLES[n]);
      model_push(SAMPLES[n], y);
      if (n < ntap - 1) expect_none("R5 priming no result");
      else begin
        wait_valid(ok);
        chk("R7 irq masked", longint'(irq), 0);
        expect_out("R1 R2 R3 20-tap result", y);
      end
    end

    // 4 taps, streaming style, both bases wrap, irq enabled (R3 R5 R6 R7)
    ntap = 4;
    cf[0] = 24'sh200000; cf[1] = -1048576; cf[2] = 24'sh080000; cf[3] = 24'sh7FFFFF;
    load_coefs(62, ntap);
    wreg(2'd1, 3);
    wreg(2'd2, 61);
    wreg(2'd3, 62);
    wreg(2'd0, 8'h81);
    model_reset();
    for (int n = 0; n < 6; n++) begin
      push(SAMPLES[n]);
      model_push(SAMPLES[n], y);
      wait_valid(ok);
      chk("R7 irq with result", longint'(irq), 1);
      expect_out(n == 0 ? "R6 history cleared" : "R5 streaming result", y);
      chk("R7 read clears valid", longint'(out_valid), 0);
      chk("R7 read clears irq", longint'(irq), 0);
    end

    // saturation (R9)
    ntap = 2;
    cf[0] = 24'sh7FFFFF; cf[1] = 24'sh7FFFFF;
    load_coefs(0, ntap);
    wreg(2'd1, 1);
    wreg(2'd2, 0);
    wreg(2'd3, 0);
    wreg(2'd0, 8'h80);
    model_reset();
    push(8388607);  model_push(8388607, y);  expect_out("R1 near full scale", y);
    push(8388607);  model_push(8388607, y);  expect_out("R9 positive clip", 8388607);
    push(-8388608); model_push(-8388608, y); expect_out("R1 mixed sign", y);
    push(-8388608); model_push(-8388608, y); expect_out("R9 negative clip", -8388608);

    // other mode holds samples, FIFO fills, extra push dropped (R4 R8)
    ntap = 1;
    cf[0] = 24'sh400000;
    load_coefs(0, 1);
    wreg(2'd1, 0);
    wreg(2'd0, 8'h90);
    for (int n = 0; n < 5; n++) push_raw(SAMPLES[n]);
    repeat (30) @(negedge clk);
    chk("R8 full after four pushes", longint'(in_full), 1);
    chk("R4 no result in mode 01", longint'(out_valid), 0);
    wreg(2'd0, 8'h80);
    model_reset();
    for (int n = 0; n < 4; n++) begin
      model_push(SAMPLES[n], y);
      expect_out("R4 R8 drained sample", y);
    end
    expect_none("R8 fifth push dropped");
    chk("R8 full cleared", longint'(in_full), 0);

    // unread result held, no further pop (R10)
    model_push(SAMPLES[5], ya);
    model_push(SAMPLES[6], yb);
    push(SAMPLES[5]);
    wait_valid(ok);
    push(SAMPLES[6]);
    repeat (30) @(negedge clk);
    chk("R10 result held", longint'($signed(out_data)), ya);
    chk("R10 still valid", longint'(out_valid), 1);
    out_rd = 1'b1;
    @(negedge clk); out_rd = 1'b0;
    expect_out("R10 next after read", yb);

    summary();
    $finish;
  end
endmodule